// File: doc/BRIEF.md
# Pixel Sum-of-Absolute-Differences Accumulator

This block scores how closely two image blocks match, for use in motion estimation. Each cycle it can accept one pair of 64-bit words. Each word packs eight unsigned 8-bit pixels: one word comes from the reference block and one from the candidate block. The block forms the eight per-pixel absolute differences and reduces them with an adder tree. It then adds the result into a running total.

A 16x16 pixel block arrives as 32 word pairs. A start pulse opens a new block and clears the total. Each valid word pair adds its eight-lane sum. The pair tagged as last closes the block: one cycle later a done strobe marks the final total, and that total stays on the output until the next start.

The whole eight-lane difference and sum finishes inside one step, so throughput is one word pair per cycle. Fetching pixels and searching over candidate positions are handled elsewhere.

Top module: `pix_sad_acc`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `sad_o` is 0 and `done_o` is 0. No block is open.
- R2: Lane k uses bits [8k+7:8k] of both `ref_i` and `cand_i`. Each lane contributes the unsigned difference |ref - cand| (0..255). The operands are never treated as signed, so 0 against 255 gives 255 in either order.
- R3: An accepted word pair adds the sum of all eight lane differences to the total. That sum is at most 2040.
- R4: A start pulse without valid sets `sad_o` to 0 on the next clock edge and opens a block.
- R5: While a block is open, each cycle with `valid_i` high adds that pair's sum to the total. The new total appears on `sad_o` on the next clock edge.
- R6: A cycle with `valid_i` low and `start_i` low leaves `sad_o` unchanged, whatever the pixel inputs hold.
- R7: An accepted pair with `last_i` high closes the block. `done_o` is high for exactly the one cycle after that pair, together with the final total.
- R8: After a block closes, `sad_o` holds its total, and valid pairs arriving before the next start are ignored.
- R9: A start in the middle of a block discards the partial total.
- R10: A full block of 32 pairs with every lane differing by 255 totals 65280, the largest possible value, on the 16-bit output without overflow.
- R11: When start and valid are high in the same cycle, the block opens with that pair's sum as the total. If last is also high, done follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new block and clears the total |
| valid_i | input | 1 | The pixel words in this cycle are to be used |
| last_i | input | 1 | Marks the final word pair of the block |
| ref_i | input | 64 | Eight reference pixels, lane k at bits [8k+7:8k] |
| cand_i | input | 64 | Eight candidate pixels, lane k at bits [8k+7:8k] |
| sad_o | output | 16 | Accumulated sum of absolute differences |
| done_o | output | 1 | One-cycle strobe: the block's total is final |

## Verification
The block has one register stage, so every result is due on the clock edge that samples its inputs. A start clear, an added pair sum, the held total and the done strobe all appear at that edge. The bench drives each input set at the falling edge and reads `sad_o` and `done_o` one nanosecond after the following rising edge. It compares them with a cycle-level model kept from the requirements, so every check looks at exactly the cycle the result is due. The difference and reduction logic is swept over all 65536 pixel pairs in single-word blocks, with the lane under test rotated. Further sequences cover full blocks, aborted blocks, idle gaps and words that arrive after a block has closed.

// File: rtl/pix_sad_pkg.sv
package pix_sad_pkg;
  localparam int unsigned PIX_W_DEF       = 8;
  localparam int unsigned LANES_DEF       = 8;
  localparam int unsigned BLOCK_WORDS_DEF = 32;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACC  = 1'b1
  } sad_state_e;
endpackage

// File: rtl/pix_absdiff.sv
module pix_absdiff #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] d_o
);
  // larger minus smaller: no sign wrap
  always_comb d_o = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
endmodule

// File: rtl/pix_add_tree.sv
module pix_add_tree #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = IN_W + $clog2(LANES)
) (
  input  logic [LANES*IN_W-1:0] in_i,
  output logic [OUT_W-1:0]      sum_o
);
  localparam int unsigned NODES = 2 * LANES - 1;

  // heap order: node i sums children 2i+1 and 2i+2, leaves at LANES-1..
  logic [OUT_W-1:0] node [NODES];

  for (genvar k = 0; k < LANES; k++) begin : g_leaf
    assign node[LANES-1+k] = OUT_W'(in_i[k*IN_W +: IN_W]);
  end

  for (genvar i = 0; i < LANES - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/pix_acc.sv
module pix_acc
  import pix_sad_pkg::*;
#(
  parameter int unsigned SUM_W = 11,
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             done_o
);
  sad_state_e       st_q;
  logic [ACC_W-1:0] acc_q;
  logic             done_q;
  logic             take;

  // start opens a block; otherwise only an open block accepts words
  assign take = valid_i && (start_i || (st_q == ST_ACC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && last_i;
      if (start_i) begin
        acc_q <= valid_i ? ACC_W'(sum_i) : '0;
        st_q  <= (valid_i && last_i) ? ST_IDLE : ST_ACC;
      end else if (take) begin
        acc_q <= acc_q + ACC_W'(sum_i);
        if (last_i) st_q <= ST_IDLE;
      end
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;
endmodule

// File: rtl/pix_sad_acc.sv
module pix_sad_acc
  import pix_sad_pkg::*;
#(
  parameter int unsigned PIX_W       = PIX_W_DEF,
  parameter int unsigned LANES       = LANES_DEF,
  parameter int unsigned BLOCK_WORDS = BLOCK_WORDS_DEF,
  localparam int unsigned WORD_W     = PIX_W * LANES,
  localparam int unsigned SUM_W      = PIX_W + $clog2(LANES),
  localparam int unsigned ACC_W      = PIX_W + $clog2(LANES * BLOCK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] ref_i,
  input  logic [WORD_W-1:0] cand_i,
  output logic [ACC_W-1:0]  sad_o,
  output logic              done_o
);
  logic [WORD_W-1:0] diff_w;
  logic [SUM_W-1:0]  word_sum;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pix_absdiff #(.W(PIX_W)) u_absdiff (
      .a_i (ref_i [k*PIX_W +: PIX_W]),
      .b_i (cand_i[k*PIX_W +: PIX_W]),
      .d_o (diff_w[k*PIX_W +: PIX_W])
    );
  end

  pix_add_tree #(
    .LANES (LANES),
    .IN_W  (PIX_W),
    .OUT_W (SUM_W)
  ) u_tree (
    .in_i  (diff_w),
    .sum_o (word_sum)
  );

  pix_acc #(
    .SUM_W (SUM_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .sum_i   (word_sum),
    .acc_o   (sad_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/pix_sad_acc_chk.sv
module pix_sad_acc_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 8,
  parameter int unsigned ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             valid_i,
  input logic             last_i,
  input logic [ACC_W-1:0] sad_o,
  input logic             done_o
);
  localparam int unsigned WORD_MAX = LANES * ((1 << PIX_W) - 1);

  p_start_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_i |=> sad_o == '0);

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !valid_i |=> $stable(sad_o));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> sad_o >= $past(sad_o));

  p_done_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && last_i));

  p_first_word_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && valid_i |=> 32'(sad_o) <= WORD_MAX);
endmodule

bind pix_sad_acc pix_sad_acc_chk #(
  .PIX_W (PIX_W),
  .LANES (LANES),
  .ACC_W (ACC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_i (valid_i),
  .last_i  (last_i),
  .sad_o   (sad_o),
  .done_o  (done_o)
);

// File: tb/pix_sad_acc_test.sv
`timescale 1ns/1ps
module pix_sad_acc_test;
  localparam int WORD_W = 64;
  localparam int ACC_W  = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              start_i, valid_i, last_i;
  logic [WORD_W-1:0] ref_i, cand_i;
  logic [ACC_W-1:0]  sad_o;
  logic              done_o;

  always #2.5 clk_i = ~clk_i;

  pix_sad_acc uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .ref_i   (ref_i),
    .cand_i  (cand_i),
    .sad_o   (sad_o),
    .done_o  (done_o)
  );

  int checks = 0;
  int fails  = 0;
  int m_acc  = 0;
  bit m_open = 0;
  bit m_done = 0;

  function automatic int word_sad(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    int s = 0;
    for (int k = 0; k < 8; k++) begin
      int x = int'(a[k*8 +: 8]);
      int y = int'(b[k*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(string tag, bit s, bit v, bit l,
                      logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    int ws;
    @(negedge clk_i);
    start_i = s; valid_i = v; last_i = l; ref_i = a; cand_i = b;
    ws = word_sad(a, b);
    m_done = 0;
    if (s) begin
      m_acc  = v ? ws : 0;
      m_open = !(v && l);
      m_done = v && l;
    end else if (v && m_open) begin
      m_acc += ws;
      if (l) begin m_open = 0; m_done = 1; end
    end
    @(posedge clk_i);
    #1;
    check({tag, " sad"}, int'(sad_o), m_acc & 16'hffff);
    check({tag, " done"}, int'(done_o), int'(m_done));
  endtask

  function automatic logic [WORD_W-1:0] fill(int seed, int mul);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = 8'((seed * mul + k * 29 + 3) & 255);
    return w;
  endfunction

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] a, b;
    rst_ni = 1'b0; start_i = 0; valid_i = 0; last_i = 0; ref_i = '0; cand_i = '0;
    #12;
    check("R1 reset sad", int'(sad_o), 0);
    check("R1 reset done", int'(done_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 after reset sad", int'(sad_o), 0);
    check("R1 after reset done", int'(done_o), 0);

    // R2 R3: every pixel pair, one-word blocks, lane under test rotating
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        int ln = (x + y) % 8;
        a = fill(x, 7);
        b = fill(y, 13);
        a[ln*8 +: 8] = 8'(x);
        b[ln*8 +: 8] = 8'(y);
        step("R2_R3 sweep", 1, 1, 1, a, b);
      end
    end

    // R10 full block at maximum difference, then R8 hold
    step("R4 open", 1, 0, 0, '0, '0);
    for (int i = 0; i < 32; i++)
      step("R10 max block", 0, 1, i == 31, {8{8'h00}}, {8{8'hff}});
    check("R10 total", int'(sad_o), 65280);
    step("R7 done drops", 0, 0, 0, '0, '0);
    step("R8 late word ignored", 0, 1, 0, fill(5, 3), fill(9, 11));
    step("R8 late last ignored", 0, 1, 1, fill(6, 3), fill(2, 11));
    check("R8 held total", int'(sad_o), 65280);

    // R5 R6 partial block with gaps
    step("R4 clear", 1, 0, 0, '0, '0);
    for (int i = 0; i < 13; i++) begin
      step("R5 accumulate", 0, 1, 0, fill(i, 17), fill(i + 40, 5));
      step("R6 gap ignored", 0, 0, 1, fill(i, 91), fill(i, 3));
    end

    // R9 abort mid block
    step("R9 abort", 1, 0, 0, fill(1, 1), fill(2, 2));
    check("R9 partial discarded", int'(sad_o), 0);
    for (int i = 0; i < 32; i++)
      step("R5 block", 0, 1, i == 31, fill(i, 37), fill(i, 71));
    step("R7 single pulse", 0, 0, 0, '0, '0);

    // R11 start with a word, continue, then start+valid+last back to back
    step("R11 start with word", 1, 1, 0, fill(3, 9), fill(4, 21));
    step("R11 next word", 0, 1, 0, fill(8, 9), fill(1, 21));
    step("R9 restart with word", 1, 1, 0, fill(12, 5), fill(2, 33));
    step("R11 close", 0, 1, 1, fill(13, 5), fill(3, 33));
    step("R11 one-word block", 1, 1, 1, {8{8'h80}}, {8{8'h7f}});
    step("R11 one-word again", 1, 1, 1, {8{8'h01}}, {8{8'hff}});
    step("R7 idle", 0, 0, 0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule